// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Logic

This block is the purely combinational arithmetic and logic unit of a small accumulator machine. Each cycle the surrounding sequencer presents a 4-bit operation code, the accumulator value, a second operand and the current flag byte. Within the same cycle the block returns the new accumulator value and the new flag byte.

The flag byte holds four status bits in its upper nibble: Zero, Subtract, Half-carry and Carry. Its lower nibble always reads as zero. The unit provides the following groups of operations:

- Binary add and subtract, with or without the incoming carry.
- The bitwise AND, XOR and OR.
- A compare that updates only the flags.
- A decimal correction that uses the Subtract flag to decide the direction of the adjustment.
- Accumulator complement, and setting or toggling of Carry.

Register storage, instruction sequencing and memory access sit outside this block.

Top module: `alu8_core`

## Requirements
- R1: The flag byte layout is Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Output flag bits 3..0 are always 0, and input flag bits 3..0 have no effect. The operation codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, XOR=5, OR=6, CMP=7, DAA=8, CPL=9, SCF=10, CCF=11.
- R2: ADD and ADC compute acc+opnd(+C for ADC). The result is the low 8 bits. C is bit 8 of the 9-bit sum, H is the carry out of bit 3 (carry-in included), N=0, and Z=1 when the result is 0.
- R3: SUB and SBC compute acc-opnd(-C for SBC). C is bit 8 of the 9-bit difference (a borrow), H is the borrow out of bit 3 (borrow-in included), N=1, and Z=1 when the result is 0.
- R4: CMP sets the flags exactly as SUB would, and the result equals acc unchanged.
- R5: AND gives H=1, N=0, C=0. XOR and OR give H=0, N=0, C=0. For all three, Z=1 when the result is 0.
- R6: DAA with N=0 works in two steps. First it adds 6 when H=1 or the low nibble of acc is greater than 9. Then it adds 0x60 when C=1 or the partial 9-bit value is greater than 0x9F.
- R7: DAA with N=1 subtracts 6 (mod 256) when H=1, then subtracts 0x60 when C=1. For both DAA paths: H is cleared, N is kept, C becomes 1 if it was 1 or bit 8 of the adjusted value is 1, and Z comes from the 8-bit result.
- R8: CPL returns ~acc and sets H=1 and N=1, keeping Z and C.
- R9: SCF sets C=1 and CCF inverts C. Both clear H and N, keep Z, and return acc unchanged.
- R10: Codes 12 to 15 return acc unchanged and pass flag bits 7..4 through unchanged.
- R11: The block has no storage. Result and flags follow their inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Incoming flag byte |
| result_out | output | 8 | New accumulator value |
| flags_out | output | 8 | New flag byte |

## Verification
Every output of this block is due in the same cycle as its inputs, because no register lies anywhere between inputs and outputs. The bench therefore changes inputs on the rising edge and samples result and flags on the following falling edge, half a cycle later. All paths have settled by then, and no new stimulus has yet been applied. A bench reference function computes the expected byte pair for each vector from the requirement text. The vectors are seeded random values mixed with directed carry, borrow, decimal-overflow and unused-code cases.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    parameter int DW = 8;
    localparam int NW = DW / 2;
    localparam int FZ = 7;
    localparam int FN = 6;
    localparam int FH = 5;
    localparam int FC = 4;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_DAA = 4'd8,
        OP_CPL = 4'd9,
        OP_SCF = 4'd10,
        OP_CCF = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic flags_t unpack_flags(input logic [DW-1:0] fb);
        flags_t f;
        f.z = fb[FZ];
        f.n = fb[FN];
        f.h = fb[FH];
        f.c = fb[FC];
        return f;
    endfunction

    function automatic logic [DW-1:0] pack_flags(input flags_t f);
        logic [DW-1:0] fb;
        fb     = '0;
        fb[FZ] = f.z;
        fb[FN] = f.n;
        fb[FH] = f.h;
        fb[FC] = f.c;
        return fb;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          hout_o
);
    logic [DW:0] wide;
    logic [NW:0] low;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
            low  = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - {{NW{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
            low  = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cin_i};
        end
        sum_o  = wide[DW-1:0];
        cout_o = wide[DW];
        hout_o = low[NW];
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
(
    input  logic [1:0]    sel_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output logic          h_o
);
    always_comb begin
        unique case (sel_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i ^ b_i;
            default: res_o = a_i | b_i;
        endcase
        h_o = (sel_i == 2'd0);
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  flags_t        f_i,
    output logic [DW-1:0] res_o,
    output flags_t        f_o
);
    localparam logic [DW:0] LO_FIX = (DW+1)'(6);
    localparam logic [DW:0] HI_FIX = (DW+1)'(6) << NW;
    localparam logic [DW:0] HI_LIM = (DW+1)'(((9 << NW) | ((1 << NW) - 1)));
    localparam logic [NW-1:0] DIG_MAX = NW'(9);

    logic [DW:0] t;

    always_comb begin
        t = {1'b0, a_i};
        if (f_i.n) begin
            if (f_i.h) t = {1'b0, t[DW-1:0] - LO_FIX[DW-1:0]};
            if (f_i.c) t = t - HI_FIX;
        end else begin
            if (f_i.h || (a_i[NW-1:0] > DIG_MAX)) t = t + LO_FIX;
            if (f_i.c || (t > HI_LIM)) t = t + HI_FIX;
        end
        res_o  = t[DW-1:0];
        f_o.z  = (t[DW-1:0] == '0);
        f_o.n  = f_i.n;
        f_o.h  = 1'b0;
        f_o.c  = f_i.c | t[DW];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [DW-1:0] flags_in,
    output logic [DW-1:0] result_out,
    output logic [DW-1:0] flags_out
);
    flags_t        fin;
    flags_t        fnew;
    alu_op_e       op;
    logic          as_sub;
    logic          as_cin;
    logic [DW-1:0] as_sum;
    logic          as_cout;
    logic          as_h;
    logic [DW-1:0] bw_res;
    logic          bw_h;
    logic [DW-1:0] da_res;
    flags_t        da_f;

    assign fin    = unpack_flags(flags_in);
    assign op     = alu_op_e'(op_code);
    assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;

    alu8_addsub u_addsub (
        .a_i    (acc_in),
        .b_i    (opnd_in),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .hout_o (as_h)
    );

    alu8_bitwise u_bitwise (
        .sel_i (op_code[1:0]),
        .a_i   (acc_in),
        .b_i   (opnd_in),
        .res_o (bw_res),
        .h_o   (bw_h)
    );

    alu8_decadj u_decadj (
        .a_i   (acc_in),
        .f_i   (fin),
        .res_o (da_res),
        .f_o   (da_f)
    );

    always_comb begin
        result_out = acc_in;
        fnew       = fin;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                if (op != OP_CMP) result_out = as_sum;
                fnew.z = (as_sum == '0);
                fnew.n = as_sub;
                fnew.h = as_h;
                fnew.c = as_cout;
            end
            OP_AND, OP_XOR, OP_OR: begin
                result_out = bw_res;
                fnew.z     = (bw_res == '0);
                fnew.n     = 1'b0;
                fnew.h     = bw_h;
                fnew.c     = 1'b0;
            end
            OP_DAA: begin
                result_out = da_res;
                fnew       = da_f;
            end
            OP_CPL: begin
                result_out = ~acc_in;
                fnew.n     = 1'b1;
                fnew.h     = 1'b1;
            end
            OP_SCF: begin
                fnew.n = 1'b0;
                fnew.h = 1'b0;
                fnew.c = 1'b1;
            end
            OP_CCF: begin
                fnew.n = 1'b0;
                fnew.h = 1'b0;
                fnew.c = ~fin.c;
            end
            default: ;
        endcase
        flags_out = pack_flags(fnew);
    end

    always_comb begin
        if (op == OP_CMP)
            assert_cmp_keeps_acc_R4: assert (result_out == acc_in);
        if ((op == OP_AND) || (op == OP_XOR) || (op == OP_OR))
            assert_logic_no_carry_R5: assert (flags_out[FC] == 1'b0 && flags_out[FN] == 1'b0);
        if ((op == OP_DAA) && fin.c)
            assert_daa_carry_sticky_R7: assert (flags_out[FC] == 1'b1);
        if ((op == OP_SUB) || (op == OP_SBC))
            assert_sub_sets_n_R3: assert (flags_out[FN] == 1'b1 && flags_out[FZ] == (result_out == '0));
        if ((op == OP_ADD) || (op == OP_ADC))
            assert_add_zero_flag_R2: assert (flags_out[FZ] == (result_out == '0) && flags_out[FN] == 1'b0);
        if (op_code >= 4'd12)
            assert_unused_passthru_R10: assert (result_out == acc_in && flags_out[7:4] == flags_in[7:4]);
    end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic [3:0] op_code;
    logic [7:0] acc_in, opnd_in, flags_in;
    logic [7:0] result_out, flags_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core u0 (
        .op_code    (op_code),
        .acc_in     (acc_in),
        .opnd_in    (opnd_in),
        .flags_in   (flags_in),
        .result_out (result_out),
        .flags_out  (flags_out)
    );

    function automatic logic [15:0] model(input int op, input int a, input int b, input int f);
        int z, n, h, c, r, t;
        z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
        r = a;
        case (op)
            0, 1: begin
                t = (op == 1) ? c : 0;
                h = (((a & 15) + (b & 15) + t) > 15) ? 1 : 0;
                r = a + b + t; c = (r >> 8) & 1; r = r & 255; n = 0; z = (r == 0);
            end
            2, 3, 7: begin
                t = (op == 3) ? c : 0;
                h = ((a & 15) < ((b & 15) + t)) ? 1 : 0;
                c = (a < (b + t)) ? 1 : 0;
                t = (a - b - t) & 255; n = 1; z = (t == 0);
                if (op != 7) r = t;
            end
            4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
            5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
            6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
            8: begin
                t = a;
                if (n == 1) begin
                    if (h == 1) t = (t - 6) & 255;
                    if (c == 1) t = t - 96;
                end else begin
                    if (h == 1 || (t & 15) > 9) t = t + 6;
                    if (c == 1 || t > 159) t = t + 96;
                end
                if (((t >> 8) & 1) == 1) c = 1;
                r = t & 255; h = 0; z = (r == 0);
            end
            9: begin r = (~a) & 255; h = 1; n = 1; end
            10: begin c = 1; h = 0; n = 0; end
            11: begin c = 1 - c; h = 0; n = 0; end
            default: ;
        endcase
        model = {r[7:0], z[0], n[0], h[0], c[0], 4'b0000};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1: return "R2";
            2, 3: return "R3";
            7: return "R4";
            4, 5, 6: return "R5";
            8: return "R6/R7";
            9: return "R8";
            10, 11: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input int op, input int a, input int b, input int f);
        logic [15:0] exp;
        @(posedge clk);
        op_code = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; flags_in = f[7:0];
        @(negedge clk);
        exp = model(op, a, b, f);
        checks++;
        if (result_out !== exp[15:8]) begin
            errors++;
            $display("FAIL %s result op=%0d a=%h b=%h f=%h got %h exp %h", req_of(op), op, a, b, f, result_out, exp[15:8]);
        end
        checks++;
        if (flags_out !== exp[7:0]) begin
            errors++;
            $display("FAIL %s flags op=%0d a=%h b=%h f=%h got %h exp %h", req_of(op), op, a, b, f, flags_out, exp[7:0]);
        end
    endtask

    task automatic expect_bytes(input string rq, input int op, input int a, input int b, input int f,
                                input int er, input int ef);
        apply(op, a, b, f);
        checks++;
        if (result_out !== er[7:0] || flags_out !== ef[7:0]) begin
            errors++;
            $display("FAIL %s directed op=%0d got %h/%h exp %h/%h", rq, op, result_out, flags_out, er, ef);
        end
    endtask

    initial begin
        op_code = 4'd0; acc_in = 8'h00; opnd_in = 8'h00; flags_in = 8'h00;
        @(negedge clk);
        checks++; // R1, R11: ADD 0+0 at start gives Z only
        if (result_out !== 8'h00 || flags_out !== 8'h80) begin
            errors++;
            $display("FAIL R1 initial got %h/%h exp 00/80", result_out, flags_out);
        end
        expect_bytes("R2", 0, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h20);
        expect_bytes("R2", 0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'hB0);
        expect_bytes("R2", 1, 8'h0E, 8'h01, 8'h1F, 8'h10, 8'h20);
        expect_bytes("R3", 3, 8'h00, 8'h00, 8'h10, 8'hFF, 8'h70);
        expect_bytes("R3", 2, 8'h42, 8'h42, 8'h00, 8'h00, 8'hC0);
        expect_bytes("R4", 7, 8'h42, 8'h42, 8'h00, 8'h42, 8'hC0);
        expect_bytes("R5", 4, 8'hF0, 8'h0F, 8'h10, 8'h00, 8'hA0);
        expect_bytes("R5", 6, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h80);
        expect_bytes("R6", 8, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h90);
        expect_bytes("R6", 8, 8'h15, 8'h00, 8'h20, 8'h1B, 8'h00);
        expect_bytes("R7", 8, 8'h0F, 8'h00, 8'h60, 8'h09, 8'h40);
        expect_bytes("R7", 8, 8'h10, 8'h00, 8'h50, 8'hB0, 8'h50);
        expect_bytes("R8", 9, 8'h35, 8'h00, 8'h90, 8'hCA, 8'hF0);
        expect_bytes("R9", 10, 8'h12, 8'h00, 8'hE0, 8'h12, 8'h90);
        expect_bytes("R9", 11, 8'h12, 8'h00, 8'h70, 8'h12, 8'h00);
        expect_bytes("R10", 14, 8'h5A, 8'hA5, 8'hDF, 8'h5A, 8'hD0);
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            apply($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R11 watchdog expired got timeout exp completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule